// File: doc/BRIEF.md
# Multi-Rate Timer Unit

This block holds three reloadable down-counters and one free-running up-counter behind a single-cycle register port. Channels 0 and 1 are 16 bits wide and channel 2 is 32 bits wide. Each of them counts down on either a main tick or a slower alternative tick. When a channel passes below zero it raises its own interrupt flag. In periodic mode the channel then restarts from its load value. In free mode it wraps to its all-ones value.

The fourth counter is 40 bits wide and counts up on a separate, faster tick. It has no interrupt output. Software reads its low 32 bits at one address, and the upper 8 bits together with the run flag at another. Each counter is a small state machine. A channel moves through the states `CH_OFF` (stopped), `CH_LOAD` (copies the load value in this cycle) and `CH_RUN` (counts). Its transitions are:
- `CH_OFF` to `CH_LOAD` on a control write with the enable bit set.
- `CH_LOAD` to `CH_RUN` unconditionally.
- `CH_RUN` to `CH_LOAD` on a load write.
- Any state to `CH_OFF` on a control write with the enable bit clear.

The free-running counter has the states `FR_STOP` and `FR_RUN`. A write to its high register picks between them.

Top module: `timer_unit`

## Requirements
- R1: After reset all counters, load values, control fields and interrupt flags are zero, and every register reads 0.
- R2: The register map is as follows. Channel i occupies byte addresses 0x10*i to 0x10*i+0xF, with the load register at offset 0x0, the value register at 0x4, the control register at 0x8 and the clear register at 0xC. The free-running low word is at 0x30 and the high register is at 0x34. Clear registers and unmapped addresses read 0.
- R3: The control register has three fields. Bit 7 is the enable, bit 6 selects periodic mode and bit 3 selects the main tick. These bits read back in place. A write with bit 7 set to a stopped channel copies the load value into the counter in the next cycle, and counting starts in the cycle after that.
- R4: In periodic mode a selected tick with the count at 0 reloads the load value, so a load value of N-1 gives an underflow every N selected ticks.
- R5: In free mode the underflow sets the count to 0xFFFF on channels 0 and 1, and to 0xFFFFFFFF on channel 2.
- R6: An underflow sets the channel's irq bit in the next cycle. Any write to the clear register drops it in the next cycle. If an underflow occurs in the same cycle as the clear write, the flag stays set.
- R7: With bit 3 clear the channel counts only on `tick_alt` and ignores `tick_main`. With bit 3 set it does the reverse.
- R8: A load write to an enabled channel also copies the new value into the counter in the cycle after the write. A load write to a stopped channel leaves the count unchanged.
- R9: Writes to a value register have no effect. A channel stopped by a control write with bit 7 clear holds its count whatever the ticks do.
- R10: Writing the high register with bit 8 set starts the 40-bit counter. It then counts up by one on each `tick_fast` cycle. Writing it with bit 8 clear stops the counter and zeroes it. The high register reads {bit 8 = running, bits 7:0 = count bits 39:32}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe for this cycle |
| reg_addr | input | 8 | Byte address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| tick_main | input | 1 | Main tick enable for the down-counters |
| tick_alt | input | 1 | Slower alternative tick enable |
| tick_fast | input | 1 | Tick enable for the 40-bit up-counter |
| irq | output | 3 | Per-channel underflow flags |

## Verification
The hardest case to reach is an underflow that lands in the very cycle in which the clear register is written. This needs a running channel at count 0, with its selected tick high, and the clear write all in one cycle. The bench tracks the expected count cycle by cycle. It ticks a short-period channel down until the expected count is 0, and only then issues the clear write together with the tick. A long random phase keeps load values small, so that underflows, reloads, tick-source changes and mid-count load writes overlap often.

// File: rtl/timer_pkg.sv
package timer_pkg;

    // Byte offsets inside one channel window
    localparam int CH_SHIFT = 4;
    localparam logic [CH_SHIFT-1:0] OFS_LOAD = 4'h0;
    localparam logic [CH_SHIFT-1:0] OFS_VAL  = 4'h4;
    localparam logic [CH_SHIFT-1:0] OFS_CTRL = 4'h8;
    localparam logic [CH_SHIFT-1:0] OFS_CLR  = 4'hC;

    // Control field positions
    localparam int CB_EN  = 7;
    localparam int CB_PER = 6;
    localparam int CB_SEL = 3;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_LOAD = 2'd1,
        CH_RUN  = 2'd2
    } ch_state_e;

    typedef enum logic {
        FR_STOP = 1'b0,
        FR_RUN  = 1'b1
    } fr_state_e;

endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
    import timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_load,
    input  logic         wr_ctrl,
    input  logic         wr_clr,
    input  logic [W-1:0] ld_data,
    input  logic         ctl_en,
    input  logic         ctl_per,
    input  logic         ctl_sel,
    input  logic         tick_main,
    input  logic         tick_alt,
    output logic [W-1:0] cnt,
    output logic [W-1:0] load_q,
    output logic         en,
    output logic         per,
    output logic         sel,
    output logic         irq,
    output logic         uf
);

    localparam logic [W-1:0] CNT_MAX = '1;

    ch_state_e state, nstate;
    logic      tick_sel;

    assign tick_sel = sel ? tick_main : tick_alt;
    assign en       = (state != CH_OFF);
    assign uf       = (state == CH_RUN) && tick_sel && (cnt == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_OFF;
        else        state <= nstate;
    end

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            CH_OFF:  if (wr_ctrl && ctl_en) nstate = CH_LOAD;
            CH_LOAD: nstate = CH_RUN;
            CH_RUN:  nstate = CH_RUN;
            default: nstate = CH_OFF;
        endcase
        if (wr_ctrl && !ctl_en)
            nstate = CH_OFF;
        else if (wr_load && state != CH_OFF)
            nstate = CH_LOAD;
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            load_q <= '0;
            per    <= 1'b0;
            sel    <= 1'b0;
            irq    <= 1'b0;
        end else begin
            if (wr_load) load_q <= ld_data;
            if (wr_ctrl) begin
                per <= ctl_per;
                sel <= ctl_sel;
            end
            unique case (state)
                CH_LOAD: cnt <= load_q;
                CH_RUN: begin
                    if (tick_sel) begin
                        if (cnt == '0) cnt <= per ? load_q : CNT_MAX;
                        else           cnt <= cnt - 1'b1;
                    end
                end
                default: cnt <= cnt;
            endcase
            if (uf)          irq <= 1'b1;
            else if (wr_clr) irq <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_frc.sv
module tmr_frc
    import timer_pkg::*;
#(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hi,
    input  logic         run_bit,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic         en
);

    fr_state_e state, nstate;

    assign en = (state == FR_RUN);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FR_STOP;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            FR_STOP: if (wr_hi && run_bit)  nstate = FR_RUN;
            FR_RUN:  if (wr_hi && !run_bit) nstate = FR_STOP;
            default: nstate = FR_STOP;
        endcase
    end

    // counter
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (wr_hi && !run_bit)      cnt <= '0;
        else if (state == FR_RUN && tick) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/timer_unit.sv
module timer_unit
    import timer_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32,
    parameter int FRC_W    = 40,
    parameter int NUM_CH   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tick_main,
    input  logic              tick_alt,
    input  logic              tick_fast,
    output logic [NUM_CH-1:0] irq
);

    localparam int HI_W = FRC_W - DATA_W;
    localparam logic [ADDR_W-1:0] FRC_LO_ADDR = ADDR_W'(NUM_CH << CH_SHIFT);
    localparam logic [ADDR_W-1:0] FRC_HI_ADDR = ADDR_W'((NUM_CH << CH_SHIFT) + 4);

    logic [NUM_CH-1:0]             ch_hit, wr_load_v, wr_ctrl_v, wr_clr_v;
    logic [NUM_CH-1:0]             en_v, per_v, sel_v, uf_v;
    logic [NUM_CH-1:0][DATA_W-1:0] cnt_x, load_x;
    logic [CH_SHIFT-1:0]           ofs;
    logic [FRC_W-1:0]              frc_cnt;
    logic                          frc_en, frc_wr;

    assign ofs    = reg_addr[CH_SHIFT-1:0];
    assign frc_wr = reg_we && (reg_addr == FRC_HI_ADDR);

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        localparam int CW = (gi == NUM_CH - 1) ? WIDE_W : NARROW_W;
        logic [CW-1:0] cnt_w, load_w;

        assign ch_hit[gi]    = (reg_addr[ADDR_W-1:CH_SHIFT] == (ADDR_W-CH_SHIFT)'(gi));
        assign wr_load_v[gi] = reg_we && ch_hit[gi] && (ofs == OFS_LOAD);
        assign wr_ctrl_v[gi] = reg_we && ch_hit[gi] && (ofs == OFS_CTRL);
        assign wr_clr_v[gi]  = reg_we && ch_hit[gi] && (ofs == OFS_CLR);

        tmr_chan #(.W(CW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_load   (wr_load_v[gi]),
            .wr_ctrl   (wr_ctrl_v[gi]),
            .wr_clr    (wr_clr_v[gi]),
            .ld_data   (reg_wdata[CW-1:0]),
            .ctl_en    (reg_wdata[CB_EN]),
            .ctl_per   (reg_wdata[CB_PER]),
            .ctl_sel   (reg_wdata[CB_SEL]),
            .tick_main (tick_main),
            .tick_alt  (tick_alt),
            .cnt       (cnt_w),
            .load_q    (load_w),
            .en        (en_v[gi]),
            .per       (per_v[gi]),
            .sel       (sel_v[gi]),
            .irq       (irq[gi]),
            .uf        (uf_v[gi])
        );

        assign cnt_x[gi]  = DATA_W'(cnt_w);
        assign load_x[gi] = DATA_W'(load_w);
    end

    tmr_frc #(.W(FRC_W)) u_frc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hi   (frc_wr),
        .run_bit (reg_wdata[HI_W]),
        .tick    (tick_fast),
        .cnt     (frc_cnt),
        .en      (frc_en)
    );

    // read mux
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_hit[i]) begin
                unique case (ofs)
                    OFS_LOAD: reg_rdata = load_x[i];
                    OFS_VAL:  reg_rdata = cnt_x[i];
                    OFS_CTRL: begin
                        reg_rdata[CB_EN]  = en_v[i];
                        reg_rdata[CB_PER] = per_v[i];
                        reg_rdata[CB_SEL] = sel_v[i];
                    end
                    default:  reg_rdata = '0;
                endcase
            end
        end
        if (reg_addr == FRC_LO_ADDR) reg_rdata = frc_cnt[DATA_W-1:0];
        if (reg_addr == FRC_HI_ADDR) reg_rdata = DATA_W'({frc_en, frc_cnt[FRC_W-1:DATA_W]});
    end

endmodule

// File: rtl/timer_unit_chk.sv
module timer_unit_chk #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32,
    parameter int FRC_W    = 40,
    parameter int NUM_CH   = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_CH-1:0]             irq,
    input logic [NUM_CH-1:0]             uf_v,
    input logic [NUM_CH-1:0]             wr_clr_v,
    input logic [NUM_CH-1:0]             en_v,
    input logic [NUM_CH-1:0]             per_v,
    input logic [NUM_CH-1:0][DATA_W-1:0] cnt_x,
    input logic [NUM_CH-1:0][DATA_W-1:0] load_x,
    input logic [FRC_W-1:0]              frc_cnt,
    input logic                          frc_en,
    input logic                          frc_wr,
    input logic                          tick_fast
);

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chk
        localparam int CW = (gi == NUM_CH - 1) ? WIDE_W : NARROW_W;
        localparam logic [DATA_W-1:0] MAXV = DATA_W'((64'd1 << CW) - 64'd1);

        AST_UF_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            uf_v[gi] |=> irq[gi]); // R6
        AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_clr_v[gi] && !uf_v[gi]) |=> !irq[gi]); // R6
        AST_IRQ_ONLY_FROM_UF: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[gi]) |-> $past(uf_v[gi])); // R6
        AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (uf_v[gi] && per_v[gi]) |=> (cnt_x[gi] == $past(load_x[gi]))); // R4
        AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (uf_v[gi] && !per_v[gi]) |=> (cnt_x[gi] == MAXV)); // R5
        AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !en_v[gi] |=> $stable(cnt_x[gi])); // R9
    end

    AST_FRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_en && tick_fast && !frc_wr) |=> (frc_cnt == $past(frc_cnt) + 1'b1)); // R10
    AST_FRC_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!frc_en && !frc_wr) |=> $stable(frc_cnt)); // R10

endmodule

bind timer_unit timer_unit_chk #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .WIDE_W   (WIDE_W),
    .FRC_W    (FRC_W),
    .NUM_CH   (NUM_CH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .uf_v      (uf_v),
    .wr_clr_v  (wr_clr_v),
    .en_v      (en_v),
    .per_v     (per_v),
    .cnt_x     (cnt_x),
    .load_x    (load_x),
    .frc_cnt   (frc_cnt),
    .frc_en    (frc_en),
    .frc_wr    (frc_wr),
    .tick_fast (tick_fast)
);

// File: tb/tb_timer_unit.sv
module tb_timer_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick_main = 1'b0, tick_alt = 1'b0, tick_fast = 1'b0;
    logic [2:0]  irq;

    always #2 clk = ~clk;

    timer_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_main(tick_main),
        .tick_alt(tick_alt), .tick_fast(tick_fast), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference state
    int          m_st[3];
    logic [31:0] m_cnt[3], m_ld[3];
    logic        m_per[3], m_sel[3], m_irq[3];
    logic        m_fen;
    logic [39:0] m_fcnt;

    function automatic logic [31:0] cmax(int i);
        return (i == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] a);
        int i;
        i = int'(a[7:4]);
        if (i < 3) begin
            case (a[3:0])
                4'h0: return m_ld[i];
                4'h4: return m_cnt[i];
                4'h8: return {24'd0, (m_st[i] != 0), m_per[i], 2'b00, m_sel[i], 3'b000};
                default: return 32'd0;
            endcase
        end
        if (a == 8'h30) return m_fcnt[31:0];
        if (a == 8'h34) return {23'd0, m_fen, m_fcnt[39:32]};
        return 32'd0;
    endfunction

    task automatic model_step(logic we, logic [7:0] a, logic [31:0] d,
                              logic tm, logic ta, logic tf);
        for (int i = 0; i < 3; i++) begin
            logic hit, wl, wc, wclr, tk, uf;
            logic [31:0] ncnt;
            int nst;
            hit  = we && (int'(a[7:4]) == i);
            wl   = hit && (a[3:0] == 4'h0);
            wc   = hit && (a[3:0] == 4'h8);
            wclr = hit && (a[3:0] == 4'hC);
            tk   = m_sel[i] ? tm : ta;
            uf   = (m_st[i] == 2) && tk && (m_cnt[i] == 0);
            ncnt = m_cnt[i];
            if (m_st[i] == 1) ncnt = m_ld[i];
            else if (m_st[i] == 2 && tk)
                ncnt = (m_cnt[i] == 0) ? (m_per[i] ? m_ld[i] : cmax(i)) : m_cnt[i] - 1;
            nst = m_st[i];
            if (m_st[i] == 0 && wc && d[7]) nst = 1;
            else if (m_st[i] == 1) nst = 2;
            if (wc && !d[7]) nst = 0;
            else if (wl && m_st[i] != 0) nst = 1;
            if (wl) m_ld[i] = d & cmax(i);
            if (wc) begin m_per[i] = d[6]; m_sel[i] = d[3]; end
            if (uf) m_irq[i] = 1'b1;
            else if (wclr) m_irq[i] = 1'b0;
            m_cnt[i] = ncnt;
            m_st[i]  = nst;
        end
        if (we && a == 8'h34) begin
            if (!d[8]) m_fcnt = '0;
            else if (m_fen && tf) m_fcnt = m_fcnt + 1;
            m_fen = d[8];
        end else if (m_fen && tf) begin
            m_fcnt = m_fcnt + 1;
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock cycle, entered and left just after a falling edge
    task automatic cyc(logic we, logic [7:0] a, logic [31:0] d,
                       logic tm, logic ta, logic tf, bit rchk, string tag);
        reg_we = we; reg_addr = a; reg_wdata = d;
        tick_main = tm; tick_alt = ta; tick_fast = tf;
        #1;
        if (rchk && !we) chk(tag, reg_rdata, exp_read(a));
        @(posedge clk);
        model_step(we, a, d, tm, ta, tf);
        @(negedge clk);
        chk(tag, {29'd0, irq}, {29'd0, m_irq[2], m_irq[1], m_irq[0]});
    endtask

    task automatic rd(logic [7:0] a, string tag);
        cyc(1'b0, a, 32'd0, 1'b0, 1'b0, 1'b0, 1'b1, tag);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
        cyc(1'b1, a, d, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic rd_lit(logic [7:0] a, logic [31:0] exp, string tag);
        reg_we = 1'b0; reg_addr = a; tick_main = 1'b0; tick_alt = 1'b0; tick_fast = 1'b0;
        #1;
        chk(tag, reg_rdata, exp);
        @(posedge clk);
        model_step(1'b0, a, 32'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] snap;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) begin
            m_st[i] = 0; m_cnt[i] = 0; m_ld[i] = 0;
            m_per[i] = 0; m_sel[i] = 0; m_irq[i] = 0;
        end
        m_fen = 0; m_fcnt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, every register reads zero
        for (int a = 0; a <= 8'h34; a += 4) rd_lit(8'(a), 32'd0, "R1");
        chk("R1", {29'd0, irq}, 32'd0);

        // R2: unmapped addresses
        rd_lit(8'h3C, 32'd0, "R2");
        rd_lit(8'h44, 32'd0, "R2");
        rd_lit(8'h02, 32'd0, "R2");

        // R3 / R8: configure stopped, then start
        wr(8'h00, 32'd4, "R8");
        wr(8'h08, 32'h48, "R3");
        rd_lit(8'h08, 32'h48, "R3");
        rd_lit(8'h04, 32'd0, "R8");
        wr(8'h08, 32'hC8, "R3");
        rd_lit(8'h08, 32'hC8, "R3");
        rd_lit(8'h04, 32'd4, "R3");
        // R4: five ticks from 4 reach underflow and reload
        for (int k = 0; k < 4; k++) cyc(1'b0, 8'h04, 32'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R4");
        chk("R4", {29'd0, irq}, 32'd0);
        cyc(1'b0, 8'h04, 32'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R4");
        chk("R6", {31'd0, irq[0]}, 32'd1);
        rd_lit(8'h04, 32'd4, "R4");
        // R6: clear
        wr(8'h0C, 32'd0, "R6");
        chk("R6", {31'd0, irq[0]}, 32'd0);
        // R6: clear coinciding with underflow keeps the flag
        while (m_cnt[0] != 0) cyc(1'b0, 8'h04, 32'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R4");
        cyc(1'b1, 8'h0C, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        chk("R6", {31'd0, irq[0]}, 32'd1);
        wr(8'h0C, 32'd0, "R6");

        // R5: wide channel free mode wraps to all ones
        wr(8'h20, 32'd2, "R5");
        wr(8'h28, 32'h88, "R5");
        while (!m_irq[2]) cyc(1'b0, 8'h24, 32'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
        rd_lit(8'h24, 32'hFFFF_FFFF, "R5");
        // R5: narrow channel free mode
        wr(8'h10, 32'd1, "R5");
        wr(8'h18, 32'h88, "R5");
        while (!m_irq[1]) cyc(1'b0, 8'h14, 32'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
        rd_lit(8'h14, 32'h0000_FFFF, "R5");

        // R7: alternative tick source
        wr(8'h18, 32'hC0, "R7");
        cyc(1'b0, 8'h14, 32'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
        snap = m_cnt[1];
        for (int k = 0; k < 3; k++) cyc(1'b0, 8'h14, 32'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
        rd_lit(8'h14, snap, "R7");
        cyc(1'b0, 8'h14, 32'd0, 1'b0, 1'b1, 1'b0, 1'b1, "R7");
        rd_lit(8'h14, snap - 1, "R7");

        // R8: load write while enabled copies in
        wr(8'h10, 32'd7, "R8");
        rd(8'h14, "R8");
        rd_lit(8'h14, 32'd7, "R8");

        // R9: value register write ignored; stopped channel holds
        wr(8'h14, 32'h1234, "R9");
        rd_lit(8'h14, 32'd7, "R9");
        wr(8'h18, 32'h40, "R9");
        for (int k = 0; k < 3; k++) cyc(1'b0, 8'h14, 32'd0, 1'b1, 1'b1, 1'b0, 1'b1, "R9");
        rd_lit(8'h14, 32'd7, "R9");

        // R10: free-running counter
        wr(8'h34, 32'h100, "R10");
        rd_lit(8'h34, 32'h100, "R10");
        for (int k = 0; k < 10; k++) cyc(1'b0, 8'h30, 32'd0, 1'b0, 1'b0, 1'b1, 1'b1, "R10");
        rd_lit(8'h30, 32'd10, "R10");
        wr(8'h34, 32'h0, "R10");
        rd_lit(8'h30, 32'd0, "R10");
        rd_lit(8'h34, 32'd0, "R10");

        // random phase
        for (int n = 0; n < 6000; n++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic        we;
            we = ($urandom_range(0, 9) < 2);
            d  = 32'd0;
            if (we) begin
                int ch;
                ch = $urandom_range(0, 3);
                if (ch == 3) begin
                    a = 8'h34;
                    d = 32'($urandom_range(0, 1)) << 8;
                end else begin
                    a = 8'((ch << 4) + ($urandom_range(0, 3) << 2));
                    case (a[3:0])
                        4'h0: d = 32'($urandom_range(0, 6));
                        4'h8: d = (32'($urandom_range(0, 3) != 0) << 7) |
                                  (32'($urandom_range(0, 1)) << 6) |
                                  (32'($urandom_range(0, 1)) << 3);
                        default: d = $urandom;
                    endcase
                end
            end else begin
                a = 8'($urandom_range(0, 13) << 2);
            end
            cyc(we, a, d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
                1'($urandom_range(0, 1)), 1'b1, "R4");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule